// File: doc/BRIEF.md
# Bit Test and Modify Unit

This block examines one bit of a 16-bit word and, depending on the requested operation, returns that bit's prior value as a carry flag and optionally forces the bit to one, forces it to zero or inverts it. The word comes either straight from a register operand or from memory. A register word completes one cycle after the start strobe and hands back the new value with a write-enable for the register file. A memory word is fetched, changed and stored back through a single request channel with a valid/ready handshake and a response strobe.

The position of the bit is always taken from the low four bits of the offset source, which is either a 16-bit register offset or an 8-bit immediate. With a register offset on a memory operand, the remaining upper offset bits form a signed count of 16-bit words that moves the accessed address away from the supplied base. An immediate never moves the address. The final address is either kept at 32 bits or cut to its low 16 bits.

Top module: `bit_test_unit`

## Requirements
- R1: The bit position is the low 4 bits of `imm_off` when `imm_form` is 1 and of `bit_off` when `imm_form` is 0; the upper bits of either source never select a bit.
- R2: `cf` carries the value the selected bit had before any change, and `cf` changes only in a cycle where `done` is high.
- R3: The `op` encoding is 00 test (word unchanged), 01 set the bit, 10 clear the bit, 11 invert the bit; `result` is the changed word (for test, the word as read), and a written word differs from the read word in at most one bit.
- R4: With `mem_form` 0, `done` is high for exactly one cycle, the cycle right after the clock edge that samples `start`, together with `cf` and `result`; `reg_we` is high only in that cycle and only for op 01, 10 or 11.
- R5: With `mem_form` 1 and `imm_form` 0, the access address is `base_addr` plus 2 times the signed value of `bit_off[15:4]`.
- R6: With `mem_form` 1 and `imm_form` 1, the access address is `base_addr` with no displacement.
- R7: With `addr_wide` 0, bits 31:16 of the access address are forced to zero after the displacement is added; with `addr_wide` 1 all 32 bits are kept.
- R8: A memory test issues exactly one read and no write; a memory set, clear or invert issues one read and then one write to the same address carrying the changed word, and `done` follows the write response. `reg_we` stays low for memory operations.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with address, write flag and write data unchanged.
- R10: `start` is ignored whenever `busy` is high; the operation in progress and the number of memory accesses are not affected.
- R11: After reset `busy`, `done`, `cf`, `reg_we` and `mem_req_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 2 | 00 test, 01 set, 10 clear, 11 invert |
| mem_form | input | 1 | 1: operand in memory, 0: operand is `reg_val` |
| imm_form | input | 1 | 1: bit offset from `imm_off`, 0: from `bit_off` |
| addr_wide | input | 1 | 1: 32-bit address, 0: address cut to 16 bits |
| reg_val | input | 16 | Register operand word |
| bit_off | input | 16 | Register bit offset |
| imm_off | input | 8 | Immediate bit offset |
| base_addr | input | 32 | Base effective address of the memory word |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 16 | Word after the operation |
| reg_we | output | 1 | Register write-enable, with `done` |
| cf | output | 1 | Prior value of the selected bit |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1: write request, 0: read request |
| mem_req_addr | output | 32 | Memory word address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid or write acknowledge |
| mem_rsp_rdata | input | 16 | Read data |

## Verification
A register operation is due exactly one cycle after its start edge, so the bench drives `start` on a falling edge and checks `done`, `reg_we`, `cf` and `result` on the very next falling edge, then confirms `done` has dropped one cycle later. Memory operations take a variable number of cycles because the bench memory withholds ready and delays its response by zero to two cycles at random; for these the bench waits on falling edges until `done` rises and checks the outputs, the access counts and addresses, and the stored word in that cycle. One cycle after each memory completion it checks that the unit is idle again, proving that a `start` pulsed mid-operation was not taken.

// File: rtl/btu_pkg.sv
package btu_pkg;

    typedef enum logic [1:0] {
        OP_TEST  = 2'b00,
        OP_SET   = 2'b01,
        OP_CLEAR = 2'b10,
        OP_FLIP  = 2'b11
    } btu_op_e;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_READ_REQ   = 3'd1,
        ST_READ_WAIT  = 3'd2,
        ST_WRITE_REQ  = 3'd3,
        ST_WRITE_WAIT = 3'd4,
        ST_DONE       = 3'd5
    } btu_state_e;

endpackage

// File: rtl/btu_addr_gen.sv
// Word address former: base plus signed word displacement taken from the
// offset bits above the bit index, then optional narrowing of the result.
module btu_addr_gen #(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 16,
    localparam int IDX_W   = $clog2(DATA_W),
    localparam int BYTE_SH = $clog2(DATA_W / 8)
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DATA_W-1:0] bit_off,
    input  logic              use_imm,
    input  logic              wide,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] NARROW_MASK =
        {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic signed [DATA_W-1:0] off_s;
    logic signed [DATA_W-1:0] words_short;
    logic        [ADDR_W-1:0] words_ext;
    logic        [ADDR_W-1:0] disp;
    logic        [ADDR_W-1:0] raw;

    assign off_s       = signed'(bit_off);
    assign words_short = off_s >>> IDX_W;
    assign words_ext   = {{(ADDR_W-DATA_W){words_short[DATA_W-1]}}, words_short};
    assign disp        = use_imm ? '0 : (words_ext << BYTE_SH);
    assign raw         = base_addr + disp;

    generate
        if (NARROW_W < ADDR_W) begin : g_narrow
            assign addr = wide ? raw : (raw & NARROW_MASK);
        end else begin : g_full
            logic wide_unused;
            assign wide_unused = wide;
            assign addr = raw;
        end
    endgenerate

endmodule

// File: rtl/btu_bit_alu.sv
// Single-bit test and modify on one word: reports the prior bit and
// produces the word with that bit set, cleared, inverted or untouched.
module btu_bit_alu
    import btu_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [IDX_W-1:0]  idx,
    input  btu_op_e           op,
    output logic              old_bit,
    output logic [DATA_W-1:0] word_out
);
    assign old_bit = word_in[idx];

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        logic hit;
        logic mod_bit;
        assign hit = (idx == IDX_W'(g));
        always_comb begin
            unique case (op)
                OP_SET:   mod_bit = 1'b1;
                OP_CLEAR: mod_bit = 1'b0;
                OP_FLIP:  mod_bit = ~word_in[g];
                default:  mod_bit = word_in[g];
            endcase
        end
        assign word_out[g] = hit ? mod_bit : word_in[g];
    end

endmodule

// File: rtl/bit_test_unit.sv
// Bit test and modify unit: register operands finish in one cycle, memory
// operands run a read-modify-write over a valid/ready request channel.
module bit_test_unit
    import btu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 32,
    parameter int IMM_W    = 8,
    parameter int NARROW_W = 16,
    localparam int IDX_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              mem_form,
    input  logic              imm_form,
    input  logic              addr_wide,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] bit_off,
    input  logic [IMM_W-1:0]  imm_off,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              reg_we,
    output logic              cf,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);

    typedef struct packed {
        btu_state_e        state;
        btu_op_e           op;
        logic              mem_form;
        logic              wide;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] rd;
        logic [DATA_W-1:0] wdata;
        logic              old_bit;
        logic              cf;
        logic [DATA_W-1:0] result;
    } regs_t;

    regs_t r_d, r_q;

    // bit index source selection; the immediate bits above the index are dropped
    logic [IDX_W-1:0] live_idx;
    logic             imm_hi_unused;
    assign live_idx      = imm_form ? imm_off[IDX_W-1:0] : bit_off[IDX_W-1:0];
    assign imm_hi_unused = ^imm_off[IMM_W-1:IDX_W];

    logic [ADDR_W-1:0] gen_addr;

    btu_addr_gen #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W)
    ) i_addr_gen (
        .base_addr (base_addr),
        .bit_off   (bit_off),
        .use_imm   (imm_form),
        .wide      (addr_wide),
        .addr      (gen_addr)
    );

    // one shared bit unit: register word at start, memory word on read return
    logic [DATA_W-1:0] alu_in;
    logic [IDX_W-1:0]  alu_idx;
    btu_op_e           alu_op;
    logic              alu_old;
    logic [DATA_W-1:0] alu_out;

    assign alu_in  = (r_q.state == ST_READ_WAIT) ? mem_rsp_rdata : reg_val;
    assign alu_idx = (r_q.state == ST_IDLE) ? live_idx : r_q.idx;
    assign alu_op  = (r_q.state == ST_IDLE) ? btu_op_e'(op) : r_q.op;

    btu_bit_alu #(
        .DATA_W (DATA_W)
    ) i_bit_alu (
        .word_in  (alu_in),
        .idx      (alu_idx),
        .op       (alu_op),
        .old_bit  (alu_old),
        .word_out (alu_out)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.op       = btu_op_e'(op);
                    r_d.idx      = live_idx;
                    r_d.mem_form = mem_form;
                    r_d.wide     = addr_wide;
                    if (mem_form) begin
                        r_d.addr  = gen_addr;
                        r_d.state = ST_READ_REQ;
                    end else begin
                        r_d.cf     = alu_old;
                        r_d.result = alu_out;
                        r_d.state  = ST_DONE;
                    end
                end
            end
            ST_READ_REQ: begin
                if (mem_req_ready) begin
                    r_d.state = ST_READ_WAIT;
                end
            end
            ST_READ_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.rd      = mem_rsp_rdata;
                    r_d.wdata   = alu_out;
                    r_d.old_bit = alu_old;
                    if (r_q.op == OP_TEST) begin
                        r_d.cf     = alu_old;
                        r_d.result = mem_rsp_rdata;
                        r_d.state  = ST_DONE;
                    end else begin
                        r_d.state = ST_WRITE_REQ;
                    end
                end
            end
            ST_WRITE_REQ: begin
                if (mem_req_ready) begin
                    r_d.state = ST_WRITE_WAIT;
                end
            end
            ST_WRITE_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.cf     = r_q.old_bit;
                    r_d.result = r_q.wdata;
                    r_d.state  = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy          = (r_q.state != ST_IDLE);
    assign done          = (r_q.state == ST_DONE);
    assign result        = r_q.result;
    assign cf            = r_q.cf;
    assign reg_we        = done && !r_q.mem_form && (r_q.op != OP_TEST);
    assign mem_req_valid = (r_q.state == ST_READ_REQ) || (r_q.state == ST_WRITE_REQ);
    assign mem_req_write = (r_q.state == ST_WRITE_REQ);
    assign mem_req_addr  = r_q.addr;
    assign mem_req_wdata = r_q.wdata;

    // R9: a stalled request holds its contents
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

    // R8: plain test never writes
    p_test_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (r_q.op != OP_TEST));

    // R2: the flag moves only with the completion strobe
    p_cf_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cf) |-> done);

    // R4: register write-enable only on completion of a modifying register op
    p_we_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (done && !$past(busy) == 1'b0 ? 1'b1 : done) && (r_q.op != OP_TEST));

    // R7: narrow addresses leave the upper half clear
    p_narrow_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !r_q.wide) |-> (mem_req_addr[ADDR_W-1:NARROW_W] == '0));

    // R3: written word differs from the word read in at most one bit
    p_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> ($countones(mem_req_wdata ^ r_q.rd) <= 1));

    // R10: the latched operation cannot change while busy
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(r_q.op) && $stable(r_q.mem_form) && $stable(r_q.addr)));

endmodule

// File: tb/test_bit_test_unit.sv
module test_bit_test_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  op;
    logic        mem_form;
    logic        imm_form;
    logic        addr_wide;
    logic [15:0] reg_val;
    logic [15:0] bit_off;
    logic [7:0]  imm_off;
    logic [31:0] base_addr;
    logic        busy;
    logic        done;
    logic [15:0] result;
    logic        reg_we;
    logic        cf;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [15:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [15:0] mem_rsp_rdata;

    always #2 clk = ~clk;

    bit_test_unit i_bit_test_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .op            (op),
        .mem_form      (mem_form),
        .imm_form      (imm_form),
        .addr_wide     (addr_wide),
        .reg_val       (reg_val),
        .bit_off       (bit_off),
        .imm_off       (imm_off),
        .base_addr     (base_addr),
        .busy          (busy),
        .done          (done),
        .result        (result),
        .reg_we        (reg_we),
        .cf            (cf),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_reads  = 0;
    int n_writes = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;
    logic [15:0] mem_model [logic [31:0]];

    bit          rsp_pending = 1'b0;
    int          rsp_lat     = 0;
    logic [15:0] rsp_word    = '0;

    function automatic logic [15:0] peek(input logic [31:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return a[15:0] ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] f_new(input logic [15:0] w, input int idx, input logic [1:0] o);
        logic [15:0] m;
        m = 16'(1) << idx;
        case (o)
            2'b01:   return w | m;
            2'b10:   return w & ~m;
            2'b11:   return w ^ m;
            default: return w;
        endcase
    endfunction

    function automatic logic [31:0] f_addr(input logic [31:0] b, input logic [15:0] off,
                                           input bit imm, input bit wide);
        int words;
        logic [31:0] a;
        words = imm ? 0 : (int'($signed(off)) >>> 4);
        a = b + 32'(words * 2);
        if (!wide) a = a & 32'h0000_FFFF;
        return a;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder: random ready, 0..2 cycle response latency
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_req_ready = 1'b0;
            if (!rst_n) begin
                rsp_pending = 1'b0;
            end else if (rsp_pending) begin
                if (rsp_lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = rsp_word;
                    rsp_pending   = 1'b0;
                end else begin
                    rsp_lat--;
                end
            end else if (mem_req_valid && ($urandom % 4) != 0) begin
                mem_req_ready = 1'b1;
                rsp_pending   = 1'b1;
                rsp_lat       = int'($urandom % 3);
                if (mem_req_write) begin
                    mem_model[mem_req_addr] = mem_req_wdata;
                    n_writes++;
                    last_wr_addr = mem_req_addr;
                    rsp_word     = 16'($urandom);
                end else begin
                    rsp_word = peek(mem_req_addr);
                    n_reads++;
                    last_rd_addr = mem_req_addr;
                end
            end
        end
    end

    // called on a falling edge with the unit idle; returns on a falling edge
    task automatic run_op(input logic [1:0] o, input bit mf, input bit imf, input bit wd,
                          input logic [15:0] rv, input logic [15:0] off,
                          input logic [7:0] imv, input logic [31:0] b, input string atag);
        int idx;
        logic [31:0] ea;
        logic [15:0] old_w;
        logic [15:0] new_w;
        int cyc;
        bit glitched;
        idx   = imf ? int'(imv[3:0]) : int'(off[3:0]);
        ea    = f_addr(b, off, imf, wd);
        old_w = mf ? peek(ea) : rv;
        new_w = f_new(old_w, idx, o);
        n_reads  = 0;
        n_writes = 0;
        op = o; mem_form = mf; imm_form = imf; addr_wide = wd;
        reg_val = rv; bit_off = off; imm_off = imv; base_addr = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!mf) begin
            chk("R4", "done one cycle after start", 32'(done), 32'd1);
            chk("R4", "reg_we", 32'(reg_we), 32'(o != 2'b00));
            chk("R3", "register result", 32'(result), 32'(new_w));
            chk("R1", "cf from selected bit", 32'(cf), 32'(old_w[idx]));
            chk("R8", "no memory request for register form", 32'(mem_req_valid), 32'd0);
            @(negedge clk);
            chk("R4", "done lasts one cycle", 32'(done), 32'd0);
        end else begin
            cyc = 0;
            glitched = 1'b0;
            while (!done && cyc < 60) begin
                if (!glitched && busy) begin
                    start = 1'b1; op = ~o; mem_form = 1'b0;
                    reg_val = ~rv; imm_form = ~imf; base_addr = ~b;
                    glitched = 1'b1;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                cyc++;
            end
            start = 1'b0;
            chk("R8", "memory op completes", 32'(done), 32'd1);
            chk("R2", "cf prior bit (memory)", 32'(cf), 32'(old_w[idx]));
            chk("R3", "memory result", 32'(result), 32'((o == 2'b00) ? old_w : new_w));
            chk("R8", "no reg_we for memory", 32'(reg_we), 32'd0);
            chk("R8", "read count", 32'(n_reads), 32'd1);
            chk("R8", "write count", 32'(n_writes), 32'(o != 2'b00));
            chk(atag, "read address", last_rd_addr, ea);
            if (o != 2'b00) begin
                chk("R8", "write address", last_wr_addr, ea);
            end
            chk("R3", "stored word", 32'(peek(ea)), 32'((o == 2'b00) ? old_w : new_w));
            @(negedge clk);
            chk("R10", "idle after op, mid-op start ignored", 32'(busy), 32'd0);
            chk("R10", "no extra completion", 32'(done), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] ro;
        void'($urandom(32'd20240917));
        rst_n = 1'b0; start = 1'b0; op = '0; mem_form = 1'b0; imm_form = 1'b0;
        addr_wide = 1'b0; reg_val = '0; bit_off = '0; imm_off = '0; base_addr = '0;
        repeat (3) @(negedge clk);
        chk("R11", "busy after reset", 32'(busy), 32'd0);
        chk("R11", "done after reset", 32'(done), 32'd0);
        chk("R11", "cf after reset", 32'(cf), 32'd0);
        chk("R11", "reg_we after reset", 32'(reg_we), 32'd0);
        chk("R11", "mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed register forms, bit 0 and bit 15, each operation
        run_op(2'b00, 0, 0, 1, 16'h8001, 16'h0000, 8'h00, 32'h0, "R1");
        run_op(2'b01, 0, 0, 1, 16'h0000, 16'h000F, 8'h00, 32'h0, "R1");
        run_op(2'b10, 0, 0, 1, 16'hFFFF, 16'hFFF0, 8'h00, 32'h0, "R1");
        run_op(2'b11, 0, 1, 1, 16'h1234, 16'h0000, 8'hF7, 32'h0, "R1");
        run_op(2'b01, 0, 1, 0, 16'h00F0, 16'h0005, 8'hA4, 32'h0, "R1");
        // directed memory forms
        run_op(2'b00, 1, 0, 1, 16'h0, 16'h0003, 8'h00, 32'h0000_1000, "R5");
        run_op(2'b01, 1, 0, 1, 16'h0, 16'hFFF5, 8'h00, 32'h0000_1000, "R5");
        run_op(2'b11, 1, 0, 1, 16'h0, 16'h7FFF, 8'h00, 32'h0000_2000, "R5");
        run_op(2'b10, 1, 1, 1, 16'h0, 16'hFFF0, 8'hF3, 32'h0000_3000, "R6");
        run_op(2'b11, 1, 1, 0, 16'h0, 16'h8000, 8'h1E, 32'hABCD_0042, "R7");
        run_op(2'b01, 1, 0, 0, 16'h0, 16'h8000, 8'h00, 32'h1234_0002, "R7");
        run_op(2'b10, 1, 0, 1, 16'h0, 16'h8000, 8'h00, 32'h1234_0002, "R7");
        run_op(2'b11, 1, 0, 1, 16'h0, 16'hFFF5, 8'h00, 32'h0000_1000, "R5");

        for (int k = 0; k < 400; k++) begin
            ro = 2'($urandom);
            run_op(ro, bit'($urandom % 3 != 0), bit'($urandom), bit'($urandom),
                   16'($urandom), 16'($urandom), 8'($urandom),
                   ((k % 2) == 0) ? (32'h0000_4000 + 32'($urandom % 16) * 2) : $urandom,
                   "R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule